// File: doc/BRIEF.md
# Static RAM Read-Timing Emulator

A clock-sampled stand-in for an asynchronous static RAM. It stores words in an internal array and reproduces the device's read timing on a synchronous bus. Read data is presented only after every input has held still for a full access time. The output drive turns on and off inside separate early and late windows. Every delay is a parameter counted in clock edges.

Synthesizable logic cannot put X or Z on a wire, so the data bus is split into three outputs. `oe` says whether the device would be driving. `rd_valid` says whether the driven word can be trusted. `rd_data` carries the word, and is zero whenever it cannot be trusted.

Inputs are sampled on every rising edge. An input change is any difference between the new sample and the previous one. That edge restarts an age counter at zero. Drive transitions happen when the age equals `T_HIZ_MIN` or `T_HIZ_MAX`. A driving flag is rewritten only at the `T_HIZ_MAX` point, and that flag chooses how a deselect is handled.

Top module: `sram_timing_emu`

## Requirements
- R1: After reset, `oe`, `rd_valid` and `rd_data` are all zero.
- R2: When `cs_n` = 0 and `we_n` = 0 at a rising edge, `wdata` is stored at `addr`, and a later read of that address returns it.
- R3: A read is active when `cs_n` = 0 and `we_n` = 1. `rd_valid` rises exactly `T_ACCESS` edges after the edge that sampled the last input change, with `rd_data` equal to the stored word at `addr`. `rd_data` then holds steady while valid.
- R4: An edge that samples any change on `addr`, `cs_n` or `we_n` clears `rd_valid` from that edge on. This includes the start of a write.
- R5: `rd_data` is zero whenever `rd_valid` is low.
- R6: Take a read that starts while the device is not driving. `oe` rises `T_HIZ_MIN` edges after the change edge, and never rises while no read is active.
- R7: After a deselect, or the start of a write, from a driving state, `oe` stays high for `T_HIZ_MAX` edges and then falls. `oe` never falls while a read is active.
- R8: A deselect that comes before the driving flag is set drops `oe` after `T_HIZ_MIN` edges.
- R9: The driving flag is updated only once inputs have been stable for `T_HIZ_MAX` edges. A deselect from a driving read that lasts fewer than `T_HIZ_MAX` edges, followed by a new read, leaves `oe` high throughout.
- R10: `rd_valid` is never high while `oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Word address |
| wdata | input | DW | Word to store during a write |
| rd_data | output | DW | Read word, zero when not valid |
| rd_valid | output | 1 | Read word is trustworthy |
| oe | output | 1 | Device would be driving the bus |

## Verification
The assertions assume that inputs change only between clock edges, so each edge sees one clean sample. They also assume the parameters are ordered `T_HIZ_MIN < T_HIZ_MAX` and `T_HIZ_MIN <= T_ACCESS`. The valid-implies-drive property depends on that ordering. The bench drives every input on the falling edge and keeps the default ordering. Its stimulus covers address churn every cycle, short and long deselects, and writes that interrupt a read, so each drive window is entered from both the driving and the non-driving state.

// File: rtl/sram_timing_emu.sv
module sram_timing_emu #(
  parameter int AW        = 8,
  parameter int DW        = 16,
  parameter int T_ACCESS  = 7,
  parameter int T_HIZ_MIN = 2,
  parameter int T_HIZ_MAX = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          oe
);
  localparam int LATEST  = (T_ACCESS > T_HIZ_MAX) ? T_ACCESS : T_HIZ_MAX;
  localparam int AGE_TOP = LATEST + 1;
  localparam int AGE_W   = $clog2(AGE_TOP + 1);
  localparam int DEPTH   = 1 << AW;

  logic [DW-1:0]    mem [DEPTH];
  logic             q_cs_n, q_we_n, driving;
  logic [AW-1:0]    q_addr;
  logic [AGE_W-1:0] age, age_n;

  wire chg   = (cs_n != q_cs_n) || (we_n != q_we_n) || (addr != q_addr);
  wire rd_in = !cs_n && we_n;
  wire wr_in = !cs_n && !we_n;
  wire rd_q  = !q_cs_n && q_we_n;

  assign age_n = chg ? '0 : (age == AGE_W'(AGE_TOP) ? age : age + 1'b1);

  always_ff @(posedge clk)
    if (wr_in) mem[addr] <= wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_cs_n  <= 1'b1;
      q_we_n  <= 1'b1;
      q_addr  <= '0;
      age     <= AGE_W'(AGE_TOP);
      driving <= 1'b0;
      oe      <= 1'b0;
    end else begin
      q_cs_n <= cs_n;
      q_we_n <= we_n;
      q_addr <= addr;
      age    <= age_n;
      if (age_n == AGE_W'(T_HIZ_MIN)) begin
        if (rd_in) oe <= 1'b1;
        else if (!driving) oe <= 1'b0;
      end
      if (age_n == AGE_W'(T_HIZ_MAX)) begin
        if (!rd_in) oe <= 1'b0;
        driving <= rd_in;
      end
    end
  end

  assign rd_valid = rd_q && (age >= AGE_W'(T_ACCESS));
  assign rd_data  = rd_valid ? mem[q_addr] : '0;

  assert_change_drops_valid_R4: assert property (@(posedge clk) disable iff (rst)
    chg |=> !rd_valid);
  assert_valid_needs_oe_R10: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> oe);
  assert_valid_data_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(rd_valid)) |-> $stable(rd_data));
  assert_oe_rise_in_read_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(oe) |-> rd_q);
  assert_oe_fall_outside_read_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(oe) |-> !rd_q);
endmodule

// File: tb/test_sram_timing_emu.sv
module test_sram_timing_emu;
  localparam int AW = 8, DW = 16, TACC = 7, HMIN = 2, HMAX = 5;

  logic clk = 0, rst = 1, cs_n = 1, we_n = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rd_data;
  logic rd_valid, oe;
  int n_chk = 0, n_bad = 0;

  sram_timing_emu #(.AW(AW), .DW(DW), .T_ACCESS(TACC), .T_HIZ_MIN(HMIN), .T_HIZ_MAX(HMAX))
    i_sram_timing_emu (.clk(clk), .rst(rst), .cs_n(cs_n), .we_n(we_n), .addr(addr),
                       .wdata(wdata), .rd_data(rd_data), .rd_valid(rd_valid), .oe(oe));

  always #5 clk = ~clk;

  // behavioural reference
  logic [DW-1:0] m_mem [1<<AW];
  logic m_cs = 1, m_we = 1, m_drv = 0, m_oe = 0;
  logic [AW-1:0] m_addr = '0;
  int m_age = 1000;

  always @(posedge clk) begin
    if (rst) begin
      m_cs = 1; m_we = 1; m_addr = '0; m_age = 1000; m_drv = 0; m_oe = 0;
    end else begin
      if (cs_n !== m_cs || we_n !== m_we || addr !== m_addr) m_age = 0;
      else if (m_age < 1000) m_age++;
      if (!cs_n && !we_n) m_mem[addr] = wdata;
      if (m_age == HMIN) begin
        if (!cs_n && we_n) m_oe = 1;
        else if (!m_drv) m_oe = 0;
      end
      if (m_age == HMAX) begin
        if (!(!cs_n && we_n)) m_oe = 0;
        m_drv = !cs_n && we_n;
      end
      m_cs = cs_n; m_we = we_n; m_addr = addr;
    end
  end

  function automatic logic exp_valid();
    return !m_cs && m_we && m_age >= TACC;
  endfunction

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  task automatic cyc();
    logic [DW-1:0] ed;
    @(negedge clk);
    if (!rst) begin
      ed = exp_valid() ? m_mem[m_addr] : '0;
      check(oe === m_oe, "R7 oe", DW'(oe), DW'(m_oe));
      check(rd_valid === exp_valid(), "R3 valid", DW'(rd_valid), DW'(exp_valid()));
      check(rd_data === ed, "R5 data", rd_data, ed);
      check(!(rd_valid && !oe), "R10 valid without oe", DW'(rd_valid), DW'(0));
    end
  endtask

  task automatic run(input int k);
    for (int i = 0; i < k; i++) cyc();
  endtask

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return DW'({a, ~a}) ^ 16'hA5C3;
  endfunction

  initial begin
    int wd;
    wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 20000) begin
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(oe === 0 && rd_valid === 0 && rd_data === 0, "R1 reset state", {oe, rd_valid, rd_data[13:0]}, '0);
    rst = 0;
    // R2: fill the array
    for (int a = 0; a < (1 << AW); a++) begin
      cs_n = 0; we_n = 0; addr = AW'(a); wdata = pat(AW'(a));
      cyc();
    end
    cs_n = 1; we_n = 1;
    run(8);
    check(oe === 0, "R7 idle after write", DW'(oe), 0);

    // R6 and R3: read from non-driving state
    cs_n = 0; addr = 8'h12;
    run(HMIN);
    check(oe === 0, "R6 oe before window", DW'(oe), 0);
    cyc();
    check(oe === 1, "R6 oe at window", DW'(oe), 1);
    run(TACC - HMIN - 1);
    check(rd_valid === 0, "R3 valid early", DW'(rd_valid), 0);
    cyc();
    check(rd_valid === 1 && rd_data === pat(8'h12), "R2 read back", rd_data, pat(8'h12));

    // R4: address change
    addr = 8'h13;
    cyc();
    check(rd_valid === 0, "R4 address change", DW'(rd_valid), 0);
    check(rd_data === 0, "R5 zero when invalid", rd_data, 0);
    run(TACC);
    check(rd_valid === 1 && rd_data === pat(8'h13), "R3 new word", rd_data, pat(8'h13));

    // R7: deselect while driving
    cs_n = 1;
    cyc();
    check(rd_valid === 0, "R4 deselect", DW'(rd_valid), 0);
    run(HMAX - 1);
    check(oe === 1, "R7 oe held", DW'(oe), 1);
    cyc();
    check(oe === 0, "R7 oe released", DW'(oe), 0);

    // R9: short deselect from driving read
    cs_n = 0; addr = 8'h40;
    run(TACC + 1);
    cs_n = 1;
    run(HMAX - 2);
    cs_n = 0;
    for (int i = 0; i < TACC + 1; i++) begin
      cyc();
      check(oe === 1, "R9 oe continuous", DW'(oe), 1);
    end
    check(rd_data === pat(8'h40), "R9 data after reselect", rd_data, pat(8'h40));

    // R4 write interrupting read, then R7 release
    we_n = 0; wdata = 16'h1234;
    cyc();
    check(rd_valid === 0, "R4 write start", DW'(rd_valid), 0);
    we_n = 1;
    run(TACC + 1);
    check(rd_data === 16'h1234, "R2 overwritten word", rd_data, 16'h1234);
    cs_n = 1;
    run(HMAX + 2);

    // R8: deselect before driving flag set
    cs_n = 0; addr = 8'h07;
    run(HMIN + 2);
    cs_n = 1;
    run(HMIN);
    check(oe === 1, "R8 oe before window", DW'(oe), 1);
    cyc();
    check(oe === 0, "R8 oe dropped", DW'(oe), 0);
    run(HMAX);

    // R4: churn every cycle
    cs_n = 0;
    for (int i = 0; i < 12; i++) begin
      addr = AW'(i * 7);
      cyc();
      check(rd_valid === 0, "R4 churn", DW'(rd_valid), 0);
    end
    run(TACC + 2);
    cs_n = 1;
    run(HMAX + 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule